// File: doc/BRIEF.md
# Six-Channel Peripheral Word Mover

This block moves 16-bit words between serial or host peripherals and data memory on behalf of the processor. It has six identical channels. Each one is bound to one of ten level-sensitive peripheral request lines, which are the transmit and receive requests of five peripherals. A channel is also told which side of the move is memory. Software programs a channel through a small register bus with a start address, an end address, a block length, an address-update mode and an end-of-block action. It then sets the channel's enable bit.

Every channel shares one memory-style port. When a granted channel moves a word, the port performs one read at the channel's current source address. On the next cycle it performs one write of that data to the current destination address. A fixed-priority arbiter picks the lowest-numbered active channel whose selected request is high. When a channel has moved its last word of a block, it can pulse an interrupt line. It then either stops or reloads and starts the next block.

Top module: `pdma_ctrl`

## Requirements
- R1: While reset is held and after it is released, `mem_rd`, `mem_wr` and `irq` are low, and every channel reads back a control word of 0 and a remaining count of 0.
- R2: A channel moves words only while the request line chosen by its select field (control bits 9:6, values 0 to 9) is high. Activity on any other request line has no effect on it.
- R3: Each word moves in two consecutive cycles: a read at the source address, then a write of the returned read data at the destination address. The two strobes are never high together, and at least one idle cycle follows every write.
- R4: When several active channels have pending requests, the lowest-numbered channel is granted. One word is moved per grant.
- R5: Control bit 1 selects the direction. A value of 1 means memory to peripheral, so the source address advances and the destination stays fixed. A value of 0 means peripheral to memory, so the destination advances and the source stays fixed.
- R6: Mode field bits 3:2 set to 0 (no update) keep both addresses constant for every word.
- R7: Mode 1 increments the memory-side address by one per word. Mode 2 increments it and wraps it back to its start address after start + length - 1.
- R8: With terminate (control bit 5) set, the channel moves exactly `length` words and then stops. Its read-back enable bit (bit 0) and its remaining count then read 0.
- R9: With terminate clear, after the last word of a block the channel restores its start addresses and count and carries on with the next block.
- R10: With interrupt enable (control bit 4) set, `irq[c]` is high for exactly one cycle, the cycle right after the write of the block's last word. With interrupt enable clear, `irq[c]` stays low.
- R11: Writing a control word with bit 0 clear stops the channel. No further words are moved for it, even while its request stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Bits 5:3 channel, bits 2:0 field (0 source, 1 destination, 2 length, 3 control, 4 remaining count, read only) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for the field at `reg_addr` |
| dreq | input | 10 | Level-sensitive peripheral request lines |
| mem_rd | output | 1 | Read strobe; data is returned on `mem_rdata` in the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | 16 | Word address for the read or the write |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, registered by the memory |
| irq | output | 6 | Per-channel end-of-block pulse |

## Verification
The bench goes after the modulo wrap. A wrap compare that is off by one would repeat or skip the address at the end of the window, and that shows up directly in the logged destination sequence. Two channels whose requests rise in the same cycle check the arbiter: a reversed priority, or rotation between grants, would interleave the logged write addresses. A channel whose bound line stays low while every other line is high catches a wrong select decode as stray writes. Terminate versus reload is checked by the word count once the block is done, and the interrupt is checked by its count and by its position right after the last logged write.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  localparam int FLD_W  = 3;
  localparam int SEL_W  = 4;
  localparam int CTRL_W = 10;

  localparam int C_EN   = 0;
  localparam int C_DIR  = 1;
  localparam int C_MODE = 2;
  localparam int C_IRQ  = 4;
  localparam int C_TERM = 5;
  localparam int C_SEL  = 6;

  typedef enum logic [FLD_W-1:0] {
    F_SRC  = 3'd0,
    F_DST  = 3'd1,
    F_LEN  = 3'd2,
    F_CTRL = 3'd3,
    F_CNT  = 3'd4
  } fld_e;

  typedef enum logic [1:0] {
    AM_FIX = 2'd0,
    AM_INC = 2'd1,
    AM_MOD = 2'd2
  } amode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RD   = 2'd1,
    S_WR   = 2'd2
  } seq_e;
endpackage

// File: rtl/pdma_agen.sv
module pdma_agen
  import pdma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  input  logic [1:0]    mode,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] last_addr;

  assign last_addr = base + len - AW'(1);

  always_comb begin
    case (mode)
      AM_INC:  nxt = cur + AW'(1);
      AM_MOD:  nxt = (cur == last_addr) ? base : cur + AW'(1);
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/pdma_chan.sv
module pdma_chan
  import pdma_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NSRC = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [FLD_W-1:0] cfg_fld,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic [NSRC-1:0]  req,
  input  logic             step,
  output logic             pend,
  output logic [AW-1:0]    cur_src,
  output logic [AW-1:0]    cur_dst,
  output logic [AW-1:0]    rdata,
  output logic             irq
);
  localparam int REQ_EXT = 1 << SEL_W;

  logic [AW-1:0]    base_src_q, base_dst_q, len_q;
  logic             dir_q, irqen_q, term_q;
  logic [1:0]       mode_q;
  logic [SEL_W-1:0] sel_q;

  logic [AW-1:0] src_q, dst_q, cnt_q;
  logic          act_q, irq_q;
  logic [AW-1:0] src_d, dst_d, cnt_d;
  logic          act_d, irq_d;

  logic [AW-1:0]      src_step, dst_step;
  logic [1:0]         src_mode, dst_mode;
  logic [REQ_EXT-1:0] req_ext;
  logic               wr_ctrl, adv, last, st_en;
  logic               unused_hi;

  assign unused_hi = &{1'b0, cfg_wdata[AW-1:CTRL_W]};

  assign src_mode = dir_q ? mode_q : AM_FIX;
  assign dst_mode = dir_q ? AM_FIX : mode_q;

  pdma_agen #(.AW(AW)) u_src_gen (
    .cur(src_q), .base(base_src_q), .len(len_q), .mode(src_mode), .nxt(src_step)
  );
  pdma_agen #(.AW(AW)) u_dst_gen (
    .cur(dst_q), .base(base_dst_q), .len(len_q), .mode(dst_mode), .nxt(dst_step)
  );

  assign req_ext = REQ_EXT'(req);
  assign pend    = act_q & req_ext[sel_q];
  assign wr_ctrl = cfg_we && (cfg_fld == F_CTRL);
  assign adv     = step && act_q && !wr_ctrl;
  assign last    = (cnt_q == AW'(1));
  assign st_en   = wr_ctrl | adv;

  always_comb begin
    act_d = act_q;
    src_d = src_q;
    dst_d = dst_q;
    cnt_d = cnt_q;
    irq_d = 1'b0;
    if (wr_ctrl) begin
      if (cfg_wdata[C_EN] && (len_q != '0)) begin
        act_d = 1'b1;
        src_d = base_src_q;
        dst_d = base_dst_q;
        cnt_d = len_q;
      end else begin
        act_d = 1'b0;
      end
    end else if (adv) begin
      if (last) begin
        irq_d = irqen_q;
        if (term_q) begin
          act_d = 1'b0;
          cnt_d = '0;
        end else begin
          src_d = base_src_q;
          dst_d = base_dst_q;
          cnt_d = len_q;
        end
      end else begin
        src_d = src_step;
        dst_d = dst_step;
        cnt_d = cnt_q - AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_src_q <= '0;
      base_dst_q <= '0;
      len_q      <= '0;
      dir_q      <= 1'b0;
      mode_q     <= 2'b00;
      irqen_q    <= 1'b0;
      term_q     <= 1'b0;
      sel_q      <= '0;
    end else if (cfg_we) begin
      if (cfg_fld == F_SRC) base_src_q <= cfg_wdata;
      if (cfg_fld == F_DST) base_dst_q <= cfg_wdata;
      if (cfg_fld == F_LEN) len_q      <= cfg_wdata;
      if (cfg_fld == F_CTRL) begin
        dir_q   <= cfg_wdata[C_DIR];
        mode_q  <= cfg_wdata[C_MODE +: 2];
        irqen_q <= cfg_wdata[C_IRQ];
        term_q  <= cfg_wdata[C_TERM];
        sel_q   <= cfg_wdata[C_SEL +: SEL_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (st_en) begin
      act_q <= act_d;
      src_q <= src_d;
      dst_q <= dst_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign cur_src = src_q;
  assign cur_dst = dst_q;
  assign irq     = irq_q;

  always_comb begin
    case (cfg_fld)
      F_SRC:   rdata = base_src_q;
      F_DST:   rdata = base_dst_q;
      F_LEN:   rdata = len_q;
      F_CTRL:  rdata = AW'({sel_q, term_q, irqen_q, mode_q, dir_q, act_q});
      F_CNT:   rdata = cnt_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pdma_arb.sv
module pdma_arb #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [IW-1:0] idx
);
  assign any = |pend;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pdma_seq.sv
module pdma_seq
  import pdma_pkg::*;
#(
  parameter int NCH = 6,
  parameter int IW  = 3,
  parameter int AW  = 16,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           any,
  input  logic [IW-1:0]  gidx,
  input  logic [AW-1:0]  src_all [NCH],
  input  logic [AW-1:0]  dst_all [NCH],
  input  logic [DW-1:0]  mem_rdata,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic [NCH-1:0] step
);
  seq_e          st_q, st_d;
  logic [IW-1:0] gnt_q, gnt_d;
  logic          gnt_en;

  always_comb begin
    st_d   = st_q;
    gnt_d  = gnt_q;
    gnt_en = 1'b0;
    case (st_q)
      S_IDLE: if (any) begin
        st_d   = S_RD;
        gnt_d  = gidx;
        gnt_en = 1'b1;
      end
      S_RD:    st_d = S_WR;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gnt_q <= '0;
    else if (gnt_en) gnt_q <= gnt_d;
  end

  assign mem_rd    = (st_q == S_RD);
  assign mem_wr    = (st_q == S_WR);
  assign mem_addr  = mem_rd ? src_all[gnt_q] : dst_all[gnt_q];
  assign mem_wdata = mem_rdata;

  always_comb begin
    for (int i = 0; i < NCH; i++) step[i] = mem_wr && (gnt_q == IW'(i));
  end
endmodule

// File: rtl/pdma_ctrl.sv
module pdma_ctrl
  import pdma_pkg::*;
#(
  parameter int NCH  = 6,
  parameter int NSRC = 10,
  parameter int AW   = 16,
  parameter int DW   = 16,
  localparam int CHW = $clog2(NCH),
  localparam int RAW = CHW + FLD_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [AW-1:0]   reg_wdata,
  output logic [AW-1:0]   reg_rdata,
  input  logic [NSRC-1:0] dreq,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic [NCH-1:0]  irq
);
  logic [1:0]     rs_q;
  logic           rst_core_n;
  logic [CHW-1:0] ch_sel;
  logic [NCH-1:0] pend, step;
  logic [AW-1:0]  src_all [NCH];
  logic [AW-1:0]  dst_all [NCH];
  logic [AW-1:0]  rd_all  [NCH];
  logic           any;
  logic [CHW-1:0] gidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  assign ch_sel = reg_addr[RAW-1:FLD_W];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pdma_chan #(.AW(AW), .NSRC(NSRC)) u_chan (
      .clk(clk), .rst_n(rst_core_n),
      .cfg_we(reg_we && (ch_sel == CHW'(c))),
      .cfg_fld(reg_addr[FLD_W-1:0]), .cfg_wdata(reg_wdata),
      .req(dreq), .step(step[c]), .pend(pend[c]),
      .cur_src(src_all[c]), .cur_dst(dst_all[c]),
      .rdata(rd_all[c]), .irq(irq[c])
    );
  end

  assign reg_rdata = (int'(ch_sel) < NCH) ? rd_all[ch_sel] : '0;

  pdma_arb #(.N(NCH), .IW(CHW)) u_arb (.pend(pend), .any(any), .idx(gidx));

  pdma_seq #(.NCH(NCH), .IW(CHW), .AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_core_n), .any(any), .gidx(gidx),
    .src_all(src_all), .dst_all(dst_all), .mem_rdata(mem_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .step(step)
  );
endmodule

module pdma_ctrl_chk #(
  parameter int NCH = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic [NCH-1:0] irq
);
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  a_r3_rd_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mem_wr);
  a_r3_wr_had_rd: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));
  a_r3_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (!mem_rd && !mem_wr));
  a_r10_irq_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |-> $past(mem_wr));
  a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));
  a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |=> !(|irq));
endmodule

bind pdma_ctrl pdma_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr), .irq(irq)
);

// File: tb/pdma_ctrl_test.sv
module pdma_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [5:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [9:0]  dreq;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [5:0]  irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  pdma_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] pat(input logic [15:0] a);
    return a ^ 16'hC3A0;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_addr);

  logic [15:0] wa [256];
  logic [15:0] wd [256];
  logic [15:0] ra [256];
  int wn = 0;
  int rn = 0;
  int ic [6] = '{default: 0};
  int ia [6] = '{default: 0};

  always @(negedge clk) begin
    if (mem_wr) begin
      wa[wn[7:0]] <= mem_addr;
      wd[wn[7:0]] <= mem_wdata;
      wn <= wn + 1;
    end
    if (mem_rd) begin
      ra[rn[7:0]] <= mem_addr;
      rn <= rn + 1;
    end
    for (int i = 0; i < 6; i++) begin
      if (irq[i]) begin
        ic[i] <= ic[i] + 1;
        ia[i] <= wn;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic wr_reg(input int ch, input int fld, input logic [15:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 6'((ch << 3) | fld); reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input int ch, input int fld, output logic [15:0] v);
    @(negedge clk);
    reg_addr = 6'((ch << 3) | fld);
    #2 v = reg_rdata;
  endtask

  function automatic logic [15:0] mk(input bit en, input bit dir, input int mode,
                                     input bit ie, input bit term, input int sel);
    return 16'({sel[3:0], term, ie, mode[1:0], dir, en});
  endfunction

  task automatic setup(input int ch, input logic [15:0] s, input logic [15:0] d,
                       input logic [15:0] len, input logic [15:0] ctrl);
    wr_reg(ch, 0, s);
    wr_reg(ch, 1, d);
    wr_reg(ch, 2, len);
    wr_reg(ch, 3, ctrl);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; dreq = '0;
    hold(4);
    chk("R1 rd strobe in reset", int'(mem_rd), 0);
    chk("R1 wr strobe in reset", int'(mem_wr), 0);
    chk("R1 irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    hold(4);
    rd_reg(0, 3, v);
    chk("R1 ctrl after reset", int'(v), 0);
    rd_reg(5, 4, v);
    chk("R1 count after reset", int'(v), 0);
    chk("R1 irq after reset", int'(irq), 0);
  endtask

  task automatic t_inc_term;
    int b, rb, bi;
    logic [15:0] v;
    b = wn; rb = rn; bi = ic[0];
    setup(0, 16'h0010, 16'h00F0, 16'd4, mk(1, 1, 1, 1, 1, 3));
    dreq[3] = 1'b1;
    hold(40);
    chk("R8 words moved with terminate", wn - b, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R5 source advances", int'(ra[rb + k]), 16 + k);
      chk("R5 destination fixed", int'(wa[b + k]), 16'h00F0);
      chk("R3 write carries read data", int'(wd[b + k]), int'(pat(16'(16 + k))));
    end
    chk("R10 one irq per block", ic[0] - bi, 1);
    chk("R10 irq after last write", ia[0], b + 4);
    rd_reg(0, 3, v);
    chk("R8 enable reads back clear", int'(v[0]), 0);
    rd_reg(0, 4, v);
    chk("R8 count reads zero", int'(v), 0);
    dreq[3] = 1'b0;
  endtask

  task automatic t_fixed;
    int b, rb, bi;
    b = wn; rb = rn; bi = ic[3];
    setup(3, 16'h00F3, 16'h0020, 16'd2, mk(1, 0, 0, 0, 1, 7));
    dreq[7] = 1'b1;
    hold(30);
    chk("R6 words moved", wn - b, 2);
    for (int k = 0; k < 2; k++) begin
      chk("R6 destination constant", int'(wa[b + k]), 16'h0020);
      chk("R6 source constant", int'(ra[rb + k]), 16'h00F3);
    end
    chk("R10 irq disabled stays low", ic[3] - bi, 0);
    dreq[7] = 1'b0;
  endtask

  task automatic t_modulo;
    int b, bi, n, n2;
    b = wn; bi = ic[4];
    setup(4, 16'h00F4, 16'h0040, 16'd3, mk(1, 0, 2, 1, 0, 8));
    dreq[8] = 1'b1;
    hold(22);
    wr_reg(4, 3, mk(0, 0, 2, 1, 0, 8));
    hold(2);
    n = wn - b;
    chk("R9 reload keeps going past one block", int'(n >= 6), 1);
    for (int k = 0; k < 6; k++)
      chk("R7 modulo destination", int'(wa[b + k]), 16'h0040 + (k % 3));
    chk("R10 irq per completed block", ic[4] - bi, n / 3);
    hold(20);
    n2 = wn - b;
    chk("R11 stopped channel idle with request high", n2, n);
    dreq[8] = 1'b0;
  endtask

  task automatic t_reload;
    int b, rb;
    b = wn; rb = rn;
    setup(5, 16'h0080, 16'h00F5, 16'd2, mk(1, 1, 1, 0, 0, 9));
    dreq[9] = 1'b1;
    hold(14);
    wr_reg(5, 3, mk(0, 1, 1, 0, 0, 9));
    dreq[9] = 1'b0;
    hold(4);
    chk("R9 words beyond block", int'((wn - b) >= 4), 1);
    for (int k = 0; k < 4; k++) begin
      chk("R9 source restarts", int'(ra[rb + k]), 16'h0080 + (k % 2));
      chk("R5 peripheral side fixed", int'(wa[b + k]), 16'h00F5);
    end
  endtask

  task automatic t_prio;
    int b;
    b = wn;
    setup(2, 16'h00F2, 16'h0070, 16'd3, mk(1, 0, 1, 0, 1, 2));
    setup(1, 16'h00F1, 16'h0060, 16'd3, mk(1, 0, 1, 0, 1, 1));
    @(negedge clk);
    dreq[1] = 1'b1; dreq[2] = 1'b1;
    hold(40);
    chk("R4 total words", wn - b, 6);
    for (int k = 0; k < 3; k++) begin
      chk("R4 low channel first", int'(wa[b + k]), 16'h0060 + k);
      chk("R4 high channel after", int'(wa[b + 3 + k]), 16'h0070 + k);
    end
    dreq = '0;
  endtask

  task automatic t_select;
    int b;
    b = wn;
    setup(0, 16'h00F0, 16'h0030, 16'd2, mk(1, 0, 1, 0, 1, 4));
    @(negedge clk);
    dreq = 10'h3EF;
    hold(20);
    chk("R2 other lines ignored", wn - b, 0);
    dreq = 10'h010;
    hold(20);
    chk("R2 bound line moves block", wn - b, 2);
    chk("R2 first destination", int'(wa[b]), 16'h0030);
    dreq = '0;
  endtask

  initial begin
    t_reset;
    t_inc_term;
    t_fixed;
    t_modulo;
    t_reload;
    t_prio;
    t_select;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule